// File: doc/BRIEF.md
# Page Buffer Self-Timed Write Engine

This block sits behind a serial memory controller and turns a write command into one page commit. The controller opens a command by pulsing `cmd_start` with the full byte address. It then delivers one pulse of `byte_vld` for each received data byte and finally pulses `stop`. Incoming bytes land in a page latch of `PAGE_BYTES` entries. Only the offset inside the page advances, so a long burst wraps to the start of the same page, and a later byte overwrites an earlier one at the same offset.

When `stop` arrives after at least one byte and the write-protect input `wp` is low at that moment, the engine raises `busy` for a fixed `WRITE_CYCLES` clock count. During that interval it sweeps the whole page through the array port in ascending offset order. Each offset receives the latched byte if one was received, and otherwise the value read back from the array. A controller uses `busy` to refuse acknowledges while polling. When `wp` is high at `stop`, the command is silently dropped and the engine stays ready.

The state machine has four states. ST_IDLE leaves on `cmd_start` to ST_COLLECT. ST_COLLECT reloads on a repeated `cmd_start`. On `stop` it moves to ST_COMMIT if a byte was received and `wp` is low, and otherwise back to ST_IDLE. ST_COMMIT moves to ST_HOLD after the last offset has been read. ST_HOLD returns to ST_IDLE once the busy countdown is zero. `busy` is high in ST_COMMIT and ST_HOLD.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy` is low and `arr_wr_en` is low, and they stay low until a command is committed.
- R2: The first byte of a command is stored at the offset given by the low log2(PAGE_BYTES) bits of `cmd_addr`. Each later byte goes to the next offset, and after offset PAGE_BYTES-1 the next offset is 0 within the same page, whose number is the upper bits of `cmd_addr`.
- R3: When more than PAGE_BYTES bytes arrive before `stop`, the later byte replaces the earlier one at the same offset.
- R4: `stop` in ST_COLLECT after at least one byte, with `wp` low, raises `busy` in the next cycle; even a single byte starts a full commit. A `stop` with no byte received returns to ST_IDLE without raising `busy`. `stop` takes priority over a `byte_vld` in the same cycle, and that byte is dropped.
- R5: A commit drives exactly PAGE_BYTES writes on consecutive cycles at offsets 0 up to PAGE_BYTES-1 of the command's page, all while `busy` is high. An offset that received a byte gets that byte. Every other offset gets the value returned on `arr_rd_data` one cycle after `arr_rd_addr` named it.
- R6: If `wp` is high in the cycle of `stop`, no write is issued, `busy` stays low, and a new `cmd_start` in the next cycle is accepted.
- R7: A change of `wp` after the `stop` cycle does not change the writes or the busy length of a commit already started.
- R8: `busy` stays high for exactly WRITE_CYCLES consecutive cycles and drops in the cycle after the countdown reaches zero. WRITE_CYCLES must be at least PAGE_BYTES+2.
- R9: While `busy` is high, `cmd_start`, `byte_vld` and `stop` are ignored. After `busy` falls, a `stop` or bytes with no new `cmd_start` start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a write command (one-cycle pulse) |
| cmd_addr | input | ADDR_W | Starting byte address, sampled with `cmd_start` |
| byte_vld | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| stop | input | 1 | End of the command (one-cycle pulse) |
| wp | input | 1 | Write protect, sampled in the `stop` cycle |
| busy | output | 1 | Self-timed write cycle in progress |
| arr_rd_addr | output | ADDR_W | Array read address during the sweep |
| arr_rd_data | input | DATA_W | Array read data, one cycle after the address |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_addr | output | ADDR_W | Array write address |
| arr_wr_data | output | DATA_W | Array write data |

## Verification
The bench starts a burst two bytes before the page end to catch an engine that carries the offset into the next page. It sends PAGE_BYTES+2 bytes to show that the first two offsets hold the last bytes, not the first ones. Every commit is compared write by write against a full expected page, so an engine that skips unwritten offsets, or writes them with stale latch data, fails at once. Further cases cover `wp` high at `stop`, where a faulty engine would still go busy or write, and `wp` rising mid-commit, where it would abort. A `stop` with no data and stimulus injected during `busy` catch an engine that starts spurious commits.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } pwe_state_e;
endpackage

// File: rtl/pwe_page_latch.sv
module pwe_page_latch #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_valid,
    input  logic              we,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [PAGE_BYTES-1:0] valid_q;
    logic [DATA_W-1:0]     cell_q [PAGE_BYTES];

    // one storage slot per page offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (clr_valid) begin
                valid_q[g] <= 1'b0;
            end else if (we && (wr_ofs == OFS_W'(g))) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (we && (wr_ofs == OFS_W'(g))) begin
                cell_q[g] <= wr_data;
            end
        end
    end

    assign rd_data  = cell_q[rd_ofs];
    assign rd_valid = valid_q[rd_ofs];
endmodule

// File: rtl/pwe_busy_timer.sv
module pwe_busy_timer #(
    parameter int WRITE_CYCLES = 1_000_000,
    localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(WRITE_CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwe_fsm.sv
module pwe_fsm
    import pwe_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int PAGE_BYTES = 128,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic              stop,
    input  logic              wp,
    input  logic              timer_zero,
    output logic              busy,
    output logic              latch_we,
    output logic              latch_clr,
    output logic              timer_load,
    output logic [OFS_W-1:0]  fill_ofs,
    output logic [PAGE_W-1:0] page_num,
    output logic [OFS_W-1:0]  sweep_ofs,
    output logic              wr_pend,
    output logic [OFS_W-1:0]  wr_ofs
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

    pwe_state_e        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ptr_q;
    logic [OFS_W-1:0]  sweep_q;
    logic [OFS_W-1:0]  wr_ofs_q;
    logic              wr_pend_q;
    logic              have_byte_q;
    logic              open_cmd;
    logic              take_byte;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (stop) state_d = (have_byte_q && !wp) ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                if (sweep_q == LAST_OFS) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (timer_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        busy       = 1'b0;
        open_cmd   = 1'b0;
        take_byte  = 1'b0;
        timer_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                open_cmd = cmd_start;
            end
            ST_COLLECT: begin
                open_cmd   = cmd_start && !stop;
                take_byte  = byte_vld && !stop && !cmd_start;
                timer_load = stop && have_byte_q && !wp;
            end
            ST_COMMIT, ST_HOLD: begin
                busy = 1'b1;
            end
            default: ;
        endcase
    end

    // command bookkeeping and sweep pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q      <= '0;
            ptr_q       <= '0;
            have_byte_q <= 1'b0;
            sweep_q     <= '0;
            wr_pend_q   <= 1'b0;
            wr_ofs_q    <= '0;
        end else begin
            if (open_cmd) begin
                page_q      <= cmd_addr[ADDR_W-1:OFS_W];
                ptr_q       <= cmd_addr[OFS_W-1:0];
                have_byte_q <= 1'b0;
            end else if (take_byte) begin
                ptr_q       <= ptr_q + 1'b1;
                have_byte_q <= 1'b1;
            end
            if (state_q == ST_COMMIT) sweep_q <= sweep_q + 1'b1;
            else                      sweep_q <= '0;
            wr_pend_q <= (state_q == ST_COMMIT);
            wr_ofs_q  <= sweep_q;
        end
    end

    assign latch_we  = take_byte;
    assign latch_clr = open_cmd;
    assign fill_ofs  = ptr_q;
    assign page_num  = page_q;
    assign sweep_ofs = sweep_q;
    assign wr_pend   = wr_pend_q;
    assign wr_ofs    = wr_ofs_q;
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine #(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop,
    input  logic              wp,
    output logic              busy,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic              arr_wr_en,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [DATA_W-1:0] arr_wr_data
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic              latch_we, latch_clr, timer_load, timer_zero;
    logic              wr_pend, held_valid;
    logic [OFS_W-1:0]  fill_ofs, sweep_ofs, wr_ofs;
    logic [PAGE_W-1:0] page_num;
    logic [DATA_W-1:0] held_data;

    pwe_fsm #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_addr   (cmd_addr),
        .byte_vld   (byte_vld),
        .stop       (stop),
        .wp         (wp),
        .timer_zero (timer_zero),
        .busy       (busy),
        .latch_we   (latch_we),
        .latch_clr  (latch_clr),
        .timer_load (timer_load),
        .fill_ofs   (fill_ofs),
        .page_num   (page_num),
        .sweep_ofs  (sweep_ofs),
        .wr_pend    (wr_pend),
        .wr_ofs     (wr_ofs)
    );

    pwe_page_latch #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_valid (latch_clr),
        .we        (latch_we),
        .wr_ofs    (fill_ofs),
        .wr_data   (byte_data),
        .rd_ofs    (wr_ofs),
        .rd_data   (held_data),
        .rd_valid  (held_valid)
    );

    pwe_busy_timer #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .run   (busy),
        .zero  (timer_zero)
    );

    // merge: received byte wins, otherwise refresh the array's own value
    assign arr_rd_addr = {page_num, sweep_ofs};
    assign arr_wr_en   = wr_pend;
    assign arr_wr_addr = {page_num, wr_ofs};
    assign arr_wr_data = held_valid ? held_data : arr_rd_data;
endmodule

// File: rtl/pwe_checker.sv
module pwe_checker #(
    parameter int ADDR_W       = 17,
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 1_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop,
    input logic              wp,
    input logic              busy,
    input logic              arr_wr_en,
    input logic [ADDR_W-1:0] arr_wr_addr
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic [31:0] busy_run_q;
    logic [31:0] wr_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run_q <= '0;
            wr_run_q   <= '0;
        end else begin
            busy_run_q <= busy ? busy_run_q + 1 : '0;
            wr_run_q   <= arr_wr_en ? wr_run_q + 1 : '0;
        end
    end

    AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> busy); // R5
    AST_SWEEP_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_wr_en) |-> (arr_wr_addr[OFS_W-1:0] == '0)); // R5
    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && $past(arr_wr_en)) |-> (arr_wr_addr == $past(arr_wr_addr) + 1'b1)); // R5
    AST_SWEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_wr_en) |-> (wr_run_q == PAGE_BYTES)); // R5
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run_q == WRITE_CYCLES)); // R8
    AST_PROTECTED_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop && wp) |=> !busy); // R6
endmodule

bind page_write_engine pwe_checker #(
    .ADDR_W       (ADDR_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_pwe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop        (stop),
    .wp          (wp),
    .busy        (busy),
    .arr_wr_en   (arr_wr_en),
    .arr_wr_addr (arr_wr_addr)
);

// File: tb/page_write_engine_bench.sv
module page_write_engine_bench;
    localparam int AW   = 10;
    localparam int DW   = 8;
    localparam int PB   = 128;
    localparam int WC   = 200;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_vld = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          stop = 1'b0;
    logic          wp = 1'b0;
    logic          busy;
    logic [AW-1:0] arr_rd_addr;
    logic [DW-1:0] arr_rd_data;
    logic          arr_wr_en;
    logic [AW-1:0] arr_wr_addr;
    logic [DW-1:0] arr_wr_data;

    logic [DW-1:0] mem [MEMN];
    logic [DW-1:0] ref_mem [MEMN];
    logic [AW+DW-1:0] exp_q [$];

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    page_write_engine #(
        .ADDR_W (AW), .DATA_W (DW), .PAGE_BYTES (PB), .WRITE_CYCLES (WC)
    ) u_page_write_engine (
        .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_addr (cmd_addr),
        .byte_vld (byte_vld), .byte_data (byte_data), .stop (stop), .wp (wp),
        .busy (busy), .arr_rd_addr (arr_rd_addr), .arr_rd_data (arr_rd_data),
        .arr_wr_en (arr_wr_en), .arr_wr_addr (arr_wr_addr), .arr_wr_data (arr_wr_data)
    );

    // array model with one-cycle read latency
    always @(posedge clk) begin
        arr_rd_data <= mem[arr_rd_addr];
        if (arr_wr_en) mem[arr_wr_addr] <= arr_wr_data;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every array write is popped and compared (R5)
    always @(negedge clk) begin
        if (rst_n && arr_wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected write", int'(arr_wr_addr), -1);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                chk({arr_wr_addr, arr_wr_data} == e, "R5 page write item",
                    int'({arr_wr_addr, arr_wr_data}), int'(e));
            end
        end
    end

    // driver: one write command, expected page pushed at stop
    task automatic write_cmd(input int addr, input int nbytes, input int seed,
                             input bit wp_stop, input bit wp_after, input string tag);
        logic [DW-1:0] buf_d [PB];
        bit            buf_v [PB];
        int            page, ofs, cnt;
        bit            commit;
        page = addr / PB;
        ofs  = addr % PB;
        for (int i = 0; i < PB; i++) buf_v[i] = 1'b0;
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_addr  = AW'(addr);
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k < nbytes; k++) begin
            byte_vld  = 1'b1;
            byte_data = DW'(seed + k);
            buf_d[(ofs + k) % PB] = DW'(seed + k);
            buf_v[(ofs + k) % PB] = 1'b1;
            @(negedge clk);
        end
        byte_vld = 1'b0;
        stop     = 1'b1;
        wp       = wp_stop;
        commit   = (nbytes > 0) && !wp_stop;
        if (commit) begin
            for (int i = 0; i < PB; i++) begin
                logic [DW-1:0] d;
                d = buf_v[i] ? buf_d[i] : ref_mem[page * PB + i];
                ref_mem[page * PB + i] = d;
                exp_q.push_back({AW'(page * PB + i), d});
            end
        end
        @(negedge clk);
        stop = 1'b0;
        wp   = wp_after;
        cnt  = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        wp = 1'b0;
        chk(cnt == (commit ? WC : 0), tag, cnt, commit ? WC : 0);
    endtask

    initial begin
        for (int i = 0; i < MEMN; i++) begin
            mem[i]     = DW'(i * 7 + 3);
            ref_mem[i] = DW'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(arr_wr_en == 1'b0, "R1 no write after reset", arr_wr_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R1 idle after release", busy, 0);

        // single byte is a full-page commit
        write_cmd(12'h085, 1, 8'hA0, 1'b0, 1'b0, "R8 busy length single byte");
        chk(mem[10'h085] == 8'hA0, "R4 single byte stored", mem[10'h085], 8'hA0);
        chk(mem[10'h086] == ref_mem[10'h086], "R5 neighbour refreshed",
            mem[10'h086], ref_mem[10'h086]);

        // wrap inside page 2
        write_cmd(12'h17E, 4, 8'h10, 1'b0, 1'b0, "R8 busy length wrap burst");
        chk(mem[10'h17E] == 8'h10, "R2 first byte at start offset", mem[10'h17E], 8'h10);
        chk(mem[10'h100] == 8'h12, "R2 wrap to page start", mem[10'h100], 8'h12);
        chk(mem[10'h101] == 8'h13, "R2 wrap second byte", mem[10'h101], 8'h13);
        chk(mem[10'h180] == ref_mem[10'h180], "R2 next page untouched",
            mem[10'h180], ref_mem[10'h180]);

        // overrun of more than one page
        write_cmd(12'h180, PB + 2, 8'h40, 1'b0, 1'b0, "R8 busy length overrun");
        chk(mem[10'h180] == DW'(8'h40 + PB), "R3 later byte wins ofs0",
            mem[10'h180], DW'(8'h40 + PB));
        chk(mem[10'h181] == DW'(8'h41 + PB), "R3 later byte wins ofs1",
            mem[10'h181], DW'(8'h41 + PB));
        chk(mem[10'h182] == 8'h42, "R3 unreplaced byte kept", mem[10'h182], 8'h42);

        // stop without data
        write_cmd(12'h200, 0, 0, 1'b0, 1'b0, "R4 empty command no busy");

        // write protected at stop, then ready at once
        write_cmd(12'h205, 3, 8'h77, 1'b1, 1'b0, "R6 protected no busy");
        chk(mem[10'h205] == ref_mem[10'h205], "R6 protected data discarded",
            mem[10'h205], ref_mem[10'h205]);
        write_cmd(12'h206, 1, 8'h55, 1'b0, 1'b0, "R6 next command accepted");
        chk(mem[10'h206] == 8'h55, "R6 follow-up write lands", mem[10'h206], 8'h55);

        // protect raised after stop
        write_cmd(12'h2C0, 2, 8'h90, 1'b0, 1'b1, "R7 busy unaffected by late wp");
        chk(mem[10'h2C1] == 8'h91, "R7 commit completed", mem[10'h2C1], 8'h91);

        // stimulus during busy is ignored
        fork
            write_cmd(12'h300, 1, 8'h21, 1'b0, 1'b0, "R8 busy length with noise");
            begin
                repeat (10) @(negedge clk);
                cmd_start = 1'b1; cmd_addr = AW'(12'h340);
                @(negedge clk);
                cmd_start = 1'b0; byte_vld = 1'b1; byte_data = 8'hEE;
                @(negedge clk);
                byte_vld = 1'b0; stop = 1'b1;
                @(negedge clk);
                stop = 1'b0;
            end
        join
        @(negedge clk);
        byte_vld = 1'b1; byte_data = 8'hEE;
        @(negedge clk);
        byte_vld = 1'b0; stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 no commit from ignored input", busy, 0);
        chk(mem[10'h340] == ref_mem[10'h340], "R9 page unchanged",
            mem[10'h340], ref_mem[10'h340]);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule